// File: doc/BRIEF.md
# Indexed PLL Configuration Commit Controller

This block sits between a simple register bus and two clock-synthesis cells. Software prepares a complete configuration in a staging area: the run enable, the output-clock enable, the lock-detect enable, a post-divider, a multiplier and a fractional part. Nothing reaches a PLL until software commits the staging area to one PLL. It does this by writing an update word whose index field names the target. That index must equal the index that software selected earlier with the update bit clear. A mismatched index, or an index beyond the implemented PLLs, discards the commit and raises a sticky error flag.

Each PLL has its own active register set. The active sets drive the enable, lock-detect enable, multiplier, fraction and post-divider outputs of that PLL, and the gating of its output clock. PLL 0 takes the staged post-divider. PLL 1 always divides by two, so any divider value committed to it is dropped. A commit that clears a PLL's enable is refused while its output clock is still ungated. The PLL must first be brought through a commit that gates its clock while the enable stays on. A start-up time field is kept for the analog side, and it can only be changed while every PLL is off.

Top module: `pll_commit_ctrl`

## Requirements
- R1: After reset, every active setting is zero: all `pll_en`, `pll_clkout_gate`, `pll_lock_en`, `pll_mul`, `pll_frac`, PLL 0's `pll_postdiv`, `commit_stb` and `startup_time` are 0. Every register reads back 0.
- R2: A commit is a write to address 0 with bit 31 set and an index in bits [3:0] equal to the selected index. At that clock edge it copies the staged settings to that PLL's outputs. `commit_stb` bit n is then high for exactly one cycle. Other PLLs are unchanged, and bit 31 of address 0 reads back as 0.
- R3: A commit whose index differs from the selected index changes no output, produces no strobe, and sets the sticky error (address 3, bit 0).
- R4: A commit whose index is 2 or more is cancelled. This holds even when that index was selected. It sets the sticky error.
- R5: Writing the staging registers only changes what they read back. Address 1 holds enable at bit 0, output-clock enable at bit 1, lock-detect enable at bit 2 and post-divider at [15:8]. Address 2 holds the multiplier at [7:0] and the fraction at [29:8]. `pll_clkout_gate` follows only a committed output-clock enable.
- R6: PLL 0's `pll_postdiv` slice equals its committed divider field. PLL 1's slice is always 1 (divide by two), whatever divider was committed to it.
- R7: A PLL that is enabled can take a new multiplier and fraction by commit without its enable dropping.
- R8: A commit with enable 0 is cancelled, with the sticky error set, when either the staged or the target's active output-clock enable is 1. Disabling therefore needs a commit that gates the clock with enable still at 1, followed by a commit that clears enable.
- R9: The start-up field (address 0, bits [15:8]) is written only by an update-bit-0 write while no `pll_en` bit is 1. Otherwise it keeps its value, while the index field is still written.
- R10: A read (`rd_en`) of address 3 returns the sticky error and clears it. An error raised in the same cycle as that read wins, and the flag stays set.
- R11: A write to address 0 with bit 31 clear selects the index and changes no active output and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (clears the error on address 3) |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pll_en | output | 2 | Committed run enable per PLL |
| pll_clkout_gate | output | 2 | Committed output-clock pass enable per PLL |
| pll_lock_en | output | 2 | Committed lock-detect enable per PLL |
| pll_postdiv | output | 16 | Post-divider per PLL, 8 bits each, PLL 0 in the low byte |
| pll_mul | output | 16 | Multiplier per PLL, 8 bits each |
| pll_frac | output | 44 | Fraction per PLL, 22 bits each |
| commit_stb | output | 2 | One-cycle pulse per PLL after a commit |
| startup_time | output | 8 | Start-up time field |

## Verification
Two functions can land in the same cycle: the clear-on-read of the sticky error and the raising of a new error by a cancelled commit. The bench presents a mismatched-index commit write and a read of address 3 in the same cycle. It expects that read to return the old flag value 0. A following read must then return 1, because setting outranks clearing. A second pairing is a start-up field write while a PLL is still enabled. There the index field must change and the start-up field must not.

// File: rtl/pcc_pkg.sv
// Package: shared field widths, register addresses and the staged
// configuration type for the PLL commit controller.
// Assumes a 32-bit bus word; widths below must fit that word.
package pcc_pkg;
    parameter int BUS_W   = 32;
    parameter int ADDR_W  = 2;
    parameter int DIV_W   = 8;
    parameter int MUL_W   = 8;
    parameter int FRAC_W  = 22;
    parameter int SU_W    = 8;

    // Word addresses
    parameter logic [ADDR_W-1:0] A_UPD  = 2'd0;
    parameter logic [ADDR_W-1:0] A_CFGA = 2'd1;
    parameter logic [ADDR_W-1:0] A_CFGB = 2'd2;
    parameter logic [ADDR_W-1:0] A_STAT = 2'd3;

    // Field positions
    parameter int UPD_BIT = 31;
    parameter int SU_LSB  = 8;
    parameter int DIV_LSB = 8;
    parameter int EN_BIT  = 0;
    parameter int OE_BIT  = 1;
    parameter int LK_BIT  = 2;

    // Fixed divider code of the second PLL (ratio minus one: divide by two)
    parameter logic [DIV_W-1:0] FIXED_DIV_CODE = 8'd1;

    typedef struct packed {
        logic              en;
        logic              clkoe;
        logic              locken;
        logic [DIV_W-1:0]  div;
        logic [MUL_W-1:0]  mul;
        logic [FRAC_W-1:0] frac;
    } pll_cfg_t;
endpackage

// File: rtl/pcc_regfile.sv
// Module: pcc_regfile
// Holds the staging registers, the selected index, the start-up field and
// the sticky error flag, and decodes the bus. Assumes one write and one
// read per cycle. An update-bit write is passed on as a request; it never
// alters the selected index or the start-up field.
module pcc_regfile
    import pcc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BUS_W-1:0]    rd_data,
    input  logic                any_en,
    input  logic                cancel,
    output pll_cfg_t            staged,
    output logic [IDX_W-1:0]    sel_idx,
    output logic [SU_W-1:0]     startup,
    output logic                upd_req,
    output logic [IDX_W-1:0]    upd_idx
);
    logic     wr_upd, wr_cfga, wr_cfgb, rd_stat;
    logic     err_q;
    pll_cfg_t stg_q;

    // Bits of the bus word that no field uses
    logic unused_wr;
    assign unused_wr = ^wr_data;

    // Address decode of the write and read strobes
    always_comb begin
        wr_upd  = wr_en && (wr_addr == A_UPD);
        wr_cfga = wr_en && (wr_addr == A_CFGA);
        wr_cfgb = wr_en && (wr_addr == A_CFGB);
        rd_stat = rd_en && (rd_addr == A_STAT);
    end

    assign upd_req = wr_upd && wr_data[UPD_BIT];
    assign upd_idx = wr_data[IDX_W-1:0];
    assign staged  = stg_q;

    // Index and start-up field: written only with the update bit clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            startup <= '0;
        end else if (wr_upd && !wr_data[UPD_BIT]) begin
            sel_idx <= wr_data[IDX_W-1:0];
            if (!any_en)
                startup <= wr_data[SU_LSB +: SU_W];
        end
    end

    // Staging registers for the next commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            if (wr_cfga) begin
                stg_q.en     <= wr_data[EN_BIT];
                stg_q.clkoe  <= wr_data[OE_BIT];
                stg_q.locken <= wr_data[LK_BIT];
                stg_q.div    <= wr_data[DIV_LSB +: DIV_W];
            end
            if (wr_cfgb) begin
                stg_q.mul  <= wr_data[MUL_W-1:0];
                stg_q.frac <= wr_data[MUL_W +: FRAC_W];
            end
        end
    end

    // Sticky error: a cancel outranks a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (cancel)
            err_q <= 1'b1;
        else if (rd_stat)
            err_q <= 1'b0;
    end

    // Read-back multiplexer; the update bit always reads as zero
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_UPD: begin
                rd_data[IDX_W-1:0]       = sel_idx;
                rd_data[SU_LSB +: SU_W]  = startup;
            end
            A_CFGA: begin
                rd_data[EN_BIT]            = stg_q.en;
                rd_data[OE_BIT]            = stg_q.clkoe;
                rd_data[LK_BIT]            = stg_q.locken;
                rd_data[DIV_LSB +: DIV_W]  = stg_q.div;
            end
            A_CFGB: begin
                rd_data[MUL_W-1:0]       = stg_q.mul;
                rd_data[MUL_W +: FRAC_W] = stg_q.frac;
            end
            default: rd_data[0] = err_q;
        endcase
    end
endmodule

// File: rtl/pcc_commit_check.sv
// Module: pcc_commit_check
// Decides whether an update request commits. It requires a matching
// in-range index and a legal shutdown order. Produces a one-hot load
// vector or a cancel. Purely combinational; assumes the request lasts one
// cycle.
module pcc_commit_check
    import pcc_pkg::*;
#(
    parameter int NPLL  = 2,
    parameter int IDX_W = 4
) (
    input  logic             upd_req,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             stg_en,
    input  logic             stg_clkoe,
    input  logic [NPLL-1:0]  act_clkoe,
    output logic [NPLL-1:0]  load,
    output logic             cancel
);
    localparam logic [IDX_W-1:0] NPLL_L = IDX_W'(NPLL);

    logic idx_ok, order_ok, tgt_clkoe;

    // Output-clock enable currently active on the targeted PLL
    always_comb begin
        tgt_clkoe = 1'b0;
        for (int i = 0; i < NPLL; i++)
            if (upd_idx == IDX_W'(i))
                tgt_clkoe = act_clkoe[i];
    end

    // Index match, range and shutdown-order rules
    always_comb begin
        idx_ok   = (upd_idx == sel_idx) && (upd_idx < NPLL_L);
        order_ok = stg_en || !(stg_clkoe || tgt_clkoe);
        cancel   = upd_req && !(idx_ok && order_ok);
    end

    // One-hot load toward the targeted active set
    always_comb begin
        for (int i = 0; i < NPLL; i++)
            load[i] = upd_req && idx_ok && order_ok && (upd_idx == IDX_W'(i));
    end
endmodule

// File: rtl/pcc_active_slot.sv
// Module: pcc_active_slot
// Active register set of one PLL. It loads the staged settings on a
// commit and pulses a strobe in the cycle after. With HAS_DIV = 0 the
// divider is not stored and a fixed divide-by-two code is driven instead.
module pcc_active_slot
    import pcc_pkg::*;
#(
    parameter bit HAS_DIV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  pll_cfg_t          staged,
    output logic              en,
    output logic              clkoe,
    output logic              locken,
    output logic [DIV_W-1:0]  div,
    output logic [MUL_W-1:0]  mul,
    output logic [FRAC_W-1:0] frac,
    output logic              stb
);
    // Common fields and commit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            clkoe  <= 1'b0;
            locken <= 1'b0;
            mul    <= '0;
            frac   <= '0;
            stb    <= 1'b0;
        end else begin
            stb <= load;
            if (load) begin
                en     <= staged.en;
                clkoe  <= staged.clkoe;
                locken <= staged.locken;
                mul    <= staged.mul;
                frac   <= staged.frac;
            end
        end
    end

    generate
        if (HAS_DIV) begin : g_prog_div
            // Programmable post-divider register
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div <= '0;
                else if (load)
                    div <= staged.div;
            end
        end else begin : g_fixed_div
            logic unused_div;
            assign unused_div = ^staged.div;
            assign div        = FIXED_DIV_CODE;
        end
    endgenerate
endmodule

// File: rtl/pll_commit_ctrl.sv
// Module: pll_commit_ctrl (top)
// Staged PLL configuration with an index-plus-update commit. Instantiates
// the register file, the commit checker and one active set per PLL. Only
// PLL 0 has a programmable post-divider.
module pll_commit_ctrl
    import pcc_pkg::*;
#(
    parameter int NPLL  = 2,
    parameter int IDX_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BUS_W-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BUS_W-1:0]         rd_data,
    output logic [NPLL-1:0]          pll_en,
    output logic [NPLL-1:0]          pll_clkout_gate,
    output logic [NPLL-1:0]          pll_lock_en,
    output logic [NPLL*DIV_W-1:0]    pll_postdiv,
    output logic [NPLL*MUL_W-1:0]    pll_mul,
    output logic [NPLL*FRAC_W-1:0]   pll_frac,
    output logic [NPLL-1:0]          commit_stb,
    output logic [SU_W-1:0]          startup_time
);
    pll_cfg_t         staged;
    logic [IDX_W-1:0] sel_idx, upd_idx;
    logic             upd_req, cancel;
    logic [NPLL-1:0]  load;

    pcc_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .any_en  (|pll_en),
        .cancel  (cancel),
        .staged  (staged),
        .sel_idx (sel_idx),
        .startup (startup_time),
        .upd_req (upd_req),
        .upd_idx (upd_idx)
    );

    pcc_commit_check #(.NPLL(NPLL), .IDX_W(IDX_W)) u_check (
        .upd_req   (upd_req),
        .upd_idx   (upd_idx),
        .sel_idx   (sel_idx),
        .stg_en    (staged.en),
        .stg_clkoe (staged.clkoe),
        .act_clkoe (pll_clkout_gate),
        .load      (load),
        .cancel    (cancel)
    );

    generate
        for (genvar i = 0; i < NPLL; i++) begin : g_slot
            pcc_active_slot #(.HAS_DIV(i == 0)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (load[i]),
                .staged (staged),
                .en     (pll_en[i]),
                .clkoe  (pll_clkout_gate[i]),
                .locken (pll_lock_en[i]),
                .div    (pll_postdiv[i*DIV_W +: DIV_W]),
                .mul    (pll_mul[i*MUL_W +: MUL_W]),
                .frac   (pll_frac[i*FRAC_W +: FRAC_W]),
                .stb    (commit_stb[i])
            );
        end
    endgenerate
endmodule

// File: rtl/pcc_checker.sv
// Module: pcc_checker
// Temporal properties of the commit controller, bound to the top module.
module pcc_checker
    import pcc_pkg::*;
#(
    parameter int NPLL = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPLL-1:0]        pll_en,
    input logic [NPLL-1:0]        pll_clkout_gate,
    input logic [NPLL*MUL_W-1:0]  pll_mul,
    input logic [NPLL*FRAC_W-1:0] pll_frac,
    input logic [NPLL-1:0]        commit_stb,
    input logic [SU_W-1:0]        startup_time
);
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_stb)); // R2

    AST_STARTUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(startup_time) |-> ($past(pll_en) == '0)); // R9

    generate
        for (genvar i = 0; i < NPLL; i++) begin : g_chk
            AST_CHANGE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable({pll_en[i], pll_mul[i*MUL_W +: MUL_W], pll_frac[i*FRAC_W +: FRAC_W]})
                |-> commit_stb[i]); // R3

            AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
                pll_clkout_gate[i] |-> pll_en[i]); // R8

            AST_SHUTDOWN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pll_en[i]) |-> !$past(pll_clkout_gate[i])); // R8
        end
    endgenerate
endmodule

bind pll_commit_ctrl pcc_checker #(.NPLL(NPLL)) u_pcc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .pll_en          (pll_en),
    .pll_clkout_gate (pll_clkout_gate),
    .pll_mul         (pll_mul),
    .pll_frac        (pll_frac),
    .commit_stb      (commit_stb),
    .startup_time    (startup_time)
);

// File: tb/pll_commit_ctrl_test.sv
// Directed bench for pll_commit_ctrl: one task per scenario.
module pll_commit_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  pll_en, pll_clkout_gate, pll_lock_en, commit_stb;
    logic [15:0] pll_postdiv, pll_mul;
    logic [43:0] pll_frac;
    logic [7:0]  startup_time;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pll_commit_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pll_en(pll_en), .pll_clkout_gate(pll_clkout_gate),
        .pll_lock_en(pll_lock_en), .pll_postdiv(pll_postdiv), .pll_mul(pll_mul),
        .pll_frac(pll_frac), .commit_stb(commit_stb), .startup_time(startup_time)
    );

    localparam logic [31:0] UPD = 32'h8000_0000;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cfga(input bit en, input bit oe, input bit lk, input logic [7:0] dv);
        wr(2'd1, {16'd0, dv, 5'd0, lk, oe, en});
    endtask

    task automatic cfgb(input logic [7:0] m, input logic [21:0] f);
        wr(2'd2, {2'd0, f, m});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(pll_en == 0 && pll_clkout_gate == 0 && pll_lock_en == 0, "R1 enables", {pll_en, pll_clkout_gate, pll_lock_en}, 0);
        check(pll_mul == 0 && pll_frac == 0 && pll_postdiv[7:0] == 0, "R1 values", pll_mul, 0);
        check(commit_stb == 0 && startup_time == 0, "R1 strobe/startup", {commit_stb, startup_time}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 0, "R1 readback", d, 0);
        end
    endtask

    task automatic t_commit_pll0;
        logic [31:0] d;
        wr(2'd0, 32'h0);
        cfga(1, 1, 1, 8'd3);
        cfgb(8'd50, 22'h1234);
        rd(2'd1, d);
        check(d == 32'h0307, "R5 staged readback", d, 32'h0307);
        check(pll_en == 0 && pll_clkout_gate == 0, "R5 staging alone", {pll_en, pll_clkout_gate}, 0);
        wr(2'd0, UPD | 32'd0);
        check(commit_stb == 2'b01, "R2 strobe", commit_stb, 1);
        check(pll_en == 2'b01 && pll_lock_en == 2'b01, "R2 enable", pll_en, 1);
        check(pll_clkout_gate == 2'b01, "R5 gate after commit", pll_clkout_gate, 1);
        check(pll_mul[7:0] == 50 && pll_frac[21:0] == 22'h1234, "R2 mul/frac", pll_mul[7:0], 50);
        check(pll_postdiv[7:0] == 3, "R6 pll0 divider", pll_postdiv[7:0], 3);
        @(negedge clk);
        check(commit_stb == 0, "R2 strobe one cycle", commit_stb, 0);
        rd(2'd0, d);
        check(d == 0, "R2 update bit reads 0", d, 0);
    endtask

    task automatic t_commit_pll1;
        wr(2'd0, 32'd1);
        check(commit_stb == 0 && pll_en == 2'b01, "R11 select only", {commit_stb, pll_en}, 1);
        cfga(1, 1, 0, 8'd9);
        cfgb(8'd20, 22'h0);
        wr(2'd0, UPD | 32'd1);
        check(commit_stb == 2'b10 && pll_en == 2'b11, "R2 pll1 commit", {commit_stb, pll_en}, 6'h0b);
        check(pll_postdiv[15:8] == 1, "R6 pll1 fixed divide", pll_postdiv[15:8], 1);
        check(pll_mul[15:8] == 20 && pll_mul[7:0] == 50, "R2 others unchanged", pll_mul, 16'h1432);
    endtask

    task automatic t_mismatch;
        logic [31:0] d;
        wr(2'd0, 32'd0);
        cfgb(8'd77, 22'h5);
        wr(2'd0, UPD | 32'd1);
        check(commit_stb == 0, "R3 no strobe", commit_stb, 0);
        check(pll_mul == 16'h1432, "R3 no change", pll_mul, 16'h1432);
        rd(2'd3, d);
        check(d == 1, "R3 error set", d, 1);
        rd(2'd3, d);
        check(d == 0, "R10 cleared by read", d, 0);
    endtask

    task automatic t_range;
        logic [31:0] d;
        wr(2'd0, 32'd3);
        wr(2'd0, UPD | 32'd3);
        check(commit_stb == 0 && pll_mul == 16'h1432, "R4 out of range", {commit_stb, pll_mul}, 16'h1432);
        rd(2'd3, d);
        check(d == 1, "R4 error set", d, 1);
    endtask

    task automatic t_reconfig;
        wr(2'd0, 32'd0);
        cfga(1, 1, 1, 8'd4);
        cfgb(8'd90, 22'h77);
        wr(2'd0, UPD | 32'd0);
        check(pll_en[0] == 1 && pll_mul[7:0] == 90, "R7 live reconfig", {pll_en[0], pll_mul[7:0]}, 9'h15a);
        check(pll_frac[21:0] == 22'h77 && pll_postdiv[7:0] == 4, "R7 frac/div", pll_frac[21:0], 22'h77);
    endtask

    task automatic t_startup_locked;
        logic [31:0] d;
        wr(2'd0, 32'h0000_4001);
        rd(2'd0, d);
        check(d == 32'h1, "R9 startup held while enabled", d, 1);
        check(startup_time == 0, "R9 startup port", startup_time, 0);
    endtask

    task automatic t_shutdown;
        logic [31:0] d;
        wr(2'd0, 32'd1);
        cfga(0, 0, 0, 8'd0);
        wr(2'd0, UPD | 32'd1);
        check(pll_en == 2'b11 && pll_clkout_gate == 2'b11, "R8 disable refused", {pll_en, pll_clkout_gate}, 4'hf);
        rd(2'd3, d);
        check(d == 1, "R8 error on bad order", d, 1);
        cfga(1, 0, 0, 8'd0);
        wr(2'd0, UPD | 32'd1);
        check(pll_en[1] == 1 && pll_clkout_gate[1] == 0, "R8 gate first", {pll_en[1], pll_clkout_gate[1]}, 2);
        cfga(0, 0, 0, 8'd0);
        wr(2'd0, UPD | 32'd1);
        check(pll_en[1] == 0 && commit_stb == 2'b10, "R8 then disable", {pll_en[1], commit_stb}, 2);
        wr(2'd0, 32'd0);
        cfga(1, 0, 0, 8'd0);
        wr(2'd0, UPD | 32'd0);
        cfga(0, 0, 0, 8'd0);
        wr(2'd0, UPD | 32'd0);
        rd(2'd3, d);
        check(pll_en == 0 && d == 0, "R8 all off no error", {pll_en, d[0]}, 0);
        wr(2'd0, 32'h0000_4000);
        check(startup_time == 8'h40, "R9 startup written when off", startup_time, 8'h40);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        wr(2'd0, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = UPD | 32'd1;
        rd_en = 1'b1; rd_addr = 2'd3;
        #1 d = rd_data;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(d == 0, "R10 same-cycle read value", d, 0);
        rd(2'd3, d);
        check(d == 1, "R10 set wins over clear", d, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit_pll0();
        t_commit_pll1();
        t_mismatch();
        t_range();
        t_reconfig();
        t_startup_locked();
        t_shutdown();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule